// File: doc/BRIEF.md
# Match-Compare System Timer with Watchdog Reset

This block is a free-running counter with four compare channels. Each channel holds a match value. When the counter reaches that value, the channel's status flag is raised, and software can route the flag to an interrupt line. The last channel, channel 3, can also act as a watchdog. Once software arms the watchdog, a channel 3 match produces a one-cycle system reset pulse.

To keep the system alive, software reads the counter, adds a margin, and writes the sum into match register 3. The reset fires only if the counter reaches that target before the next such write. The arm latch is sticky. After it is set, only the block's reset clears it. Neither the watchdog-enable register nor the channel 3 interrupt enable can stop a pending watchdog reset.

Software reaches every register through a single-cycle port. Writes take effect at the next clock edge. Read data is combinational in the same cycle as the read enable.

Top module: `ostimer_wdog`

## Requirements
- R1: The counter advances by one on every clock and wraps from 0xFFFFFFFF to 0. It reads back at offset 0x10, and a write there loads the written value at the next edge.
- R2: Channel n has its match register at offset 4·n (n = 0..3). Flag n in bit n of the status register (offset 0x14) rises on the same edge at which the counter takes the value in match register n. It is therefore visible while the counter reads that value.
- R3: Writing the status register clears each flag whose written bit is 1 and leaves the flags written with 0 unchanged.
- R4: A match reached on the same edge as a clear of that flag leaves the flag set.
- R5: irq_o[n] is high exactly when flag n is set and bit n of the interrupt-enable register (offset 0x1C) is 1.
- R6: Compare is by exact equality, so a match value just past the wrap point is hit after the counter wraps.
- R7: Writing 1 to bit 0 of offset 0x18 arms the watchdog. While armed, the counter reaching match register 3 drives wd_rst_o high for exactly the one cycle in which the counter holds that value. This happens regardless of the interrupt-enable register.
- R8: While armed, rewriting match register 3 with (counter + margin) before the counter reaches the old value prevents any reset pulse. The pulse comes only once the rewrites stop.
- R9: Once armed, the watchdog stays armed. Writing 0 to offset 0x18 or clearing interrupt enable bit 3 neither disarms it nor suppresses the reset. Offset 0x18 bit 0 reads back 1.
- R10: While not armed, a channel 3 match sets flag 3 and may raise irq_o[3], but never asserts wd_rst_o.
- R11: Synchronous reset clears the counter, all match registers, all flags, the interrupt enables and the arm latch, and holds wd_rst_o low.
- R12: Reads return zero when bus_re_i is low, and they also return zero at unaligned offsets and offsets 0x20 and above. Writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the counter advances on each rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | ADDR_W (6) | Byte offset of the register accessed |
| bus_wdata_i | input | CNT_W (32) | Write data |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_re_i | input | 1 | Read strobe |
| bus_rdata_o | output | CNT_W (32) | Read data, valid in the cycle of bus_re_i |
| irq_o | output | 4 | Per-channel interrupt, flag AND enable |
| wd_rst_o | output | 1 | One-cycle watchdog system reset pulse |

## Verification
Each channel is given a match a few cycles ahead. The flag is sampled one cycle before the target and at the target, which separates correct edge timing from an off-by-one compare. All sixteen interrupt-enable patterns are applied over a fully set status register, and then over a partially cleared one, to show gating per bit. A counter preset just below the wrap distinguishes exact-equality compare from any magnitude compare. Three watchdog scenarios are compared by pulse count and pulse position: no kick, steady kicks within the margin, and an attempted disarm through both enable registers. An unarmed channel 3 match confirms that the flag and the reset are separate.

// File: rtl/ostw_pkg.sv
package ostw_pkg;

    localparam int NUM_CH = 4;
    localparam int WD_CH  = NUM_CH - 1;

    typedef enum logic [2:0] {
        SEL_MATCH0 = 3'd0,
        SEL_MATCH1 = 3'd1,
        SEL_MATCH2 = 3'd2,
        SEL_MATCH3 = 3'd3,
        SEL_COUNT  = 3'd4,
        SEL_STATUS = 3'd5,
        SEL_WDEN   = 3'd6,
        SEL_INTEN  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic     valid;
        reg_sel_e sel;
    } reg_dec_t;

    // Word-aligned offsets below 0x20 are mapped; everything else is a hole.
    function automatic reg_dec_t decode_offset(input logic [31:0] off);
        reg_dec_t d;
        d.valid = (off[1:0] == 2'b00) && (off[31:5] == '0);
        d.sel   = reg_sel_e'(off[4:2]);
        return d;
    endfunction

endpackage

// File: rtl/ostw_counter.sv
module ostw_counter #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cnt_nxt_o
);

    // Next value is exported so compares line up with the edge that lands on it.
    always_comb begin
        if (load_i) cnt_nxt_o = load_val_i;
        else        cnt_nxt_o = cnt_o + W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_o <= '0;
        else       cnt_o <= cnt_nxt_o;
    end

endmodule

// File: rtl/ostw_channel.sv
module ostw_channel #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         wr_i,
    input  logic [W-1:0] wr_val_i,
    input  logic [W-1:0] cnt_nxt_i,
    input  logic         clr_i,
    output logic [W-1:0] match_o,
    output logic         hit_o,
    output logic         flag_o
);

    assign hit_o = (cnt_nxt_i == match_o);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            match_o <= '0;
            flag_o  <= 1'b0;
        end else begin
            if (wr_i) match_o <= wr_val_i;
            // A fresh hit outranks a simultaneous write-one clear.
            flag_o <= hit_o | (flag_o & ~clr_i);
        end
    end

endmodule

// File: rtl/ostw_wdog.sv
module ostw_wdog (
    input  logic clk_i,
    input  logic rst_i,
    input  logic arm_wr_i,
    input  logic arm_bit_i,
    input  logic hit_i,
    output logic armed_o,
    output logic pulse_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            armed_o <= 1'b0;
            pulse_o <= 1'b0;
        end else begin
            armed_o <= armed_o | (arm_wr_i & arm_bit_i);
            pulse_o <= armed_o & hit_i;
        end
    end

endmodule

// File: rtl/ostimer_wdog.sv
module ostimer_wdog
    import ostw_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [CNT_W-1:0]  bus_wdata_i,
    input  logic              bus_we_i,
    input  logic              bus_re_i,
    output logic [CNT_W-1:0]  bus_rdata_o,
    output logic [NUM_CH-1:0] irq_o,
    output logic              wd_rst_o
);

    reg_dec_t dec;
    assign dec = decode_offset(32'(bus_addr_i));

    logic wr_cnt, wr_stat, wr_wden, wr_ien;
    assign wr_cnt  = bus_we_i & dec.valid & (dec.sel == SEL_COUNT);
    assign wr_stat = bus_we_i & dec.valid & (dec.sel == SEL_STATUS);
    assign wr_wden = bus_we_i & dec.valid & (dec.sel == SEL_WDEN);
    assign wr_ien  = bus_we_i & dec.valid & (dec.sel == SEL_INTEN);

    logic [CNT_W-1:0] cnt_q, cnt_nxt;

    ostw_counter #(.W(CNT_W)) u_counter (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (wr_cnt),
        .load_val_i (bus_wdata_i),
        .cnt_o      (cnt_q),
        .cnt_nxt_o  (cnt_nxt)
    );

    logic [NUM_CH-1:0][CNT_W-1:0] match_all;
    logic [NUM_CH-1:0]            hit_all;
    logic [NUM_CH-1:0]            status_q;

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
        logic wr_m;
        assign wr_m = bus_we_i & dec.valid & (3'(dec.sel) == 3'(n));

        ostw_channel #(.W(CNT_W)) u_chan (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .wr_i      (wr_m),
            .wr_val_i  (bus_wdata_i),
            .cnt_nxt_i (cnt_nxt),
            .clr_i     (wr_stat & bus_wdata_i[n]),
            .match_o   (match_all[n]),
            .hit_o     (hit_all[n]),
            .flag_o    (status_q[n])
        );
    end

    logic [NUM_CH-1:0] ier_q;
    always_ff @(posedge clk_i) begin
        if (rst_i)       ier_q <= '0;
        else if (wr_ien) ier_q <= bus_wdata_i[NUM_CH-1:0];
    end

    assign irq_o = status_q & ier_q;

    logic armed_q;

    ostw_wdog u_wdog (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .arm_wr_i  (wr_wden),
        .arm_bit_i (bus_wdata_i[0]),
        .hit_i     (hit_all[WD_CH]),
        .armed_o   (armed_q),
        .pulse_o   (wd_rst_o)
    );

    logic [1:0]       msel;
    logic [CNT_W-1:0] rd_val;
    assign msel = dec.sel[1:0];

    always_comb begin
        case (dec.sel)
            SEL_COUNT:  rd_val = cnt_q;
            SEL_STATUS: rd_val = CNT_W'(status_q);
            SEL_WDEN:   rd_val = CNT_W'(armed_q);
            SEL_INTEN:  rd_val = CNT_W'(ier_q);
            default:    rd_val = match_all[msel];
        endcase
    end

    assign bus_rdata_o = (bus_re_i && dec.valid) ? rd_val : '0;

endmodule

// File: rtl/ostw_checker.sv
module ostw_checker
    import ostw_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 6
) (
    input logic                         clk_i,
    input logic                         rst_i,
    input logic                         bus_we_i,
    input logic [ADDR_W-1:0]            bus_addr_i,
    input logic [CNT_W-1:0]             cnt_i,
    input logic [NUM_CH-1:0][CNT_W-1:0] match_i,
    input logic [NUM_CH-1:0]            status_i,
    input logic [NUM_CH-1:0]            irq_i,
    input logic                         armed_i,
    input logic                         wd_rst_i
);

    AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        !(bus_we_i && 32'(bus_addr_i) == 32'h10) |=> cnt_i == $past(cnt_i) + CNT_W'(1)); // R1

    for (genvar n = 0; n < NUM_CH; n++) begin : g_flag
        AST_FLAG_ON_MATCH: assert property (@(posedge clk_i) disable iff (rst_i)
            (!$past(rst_i) && cnt_i == match_i[n] && $past(match_i[n]) == match_i[n])
            |-> status_i[n]); // R2
    end

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_i & ~status_i) == '0); // R5

    AST_ARM_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        armed_i |=> armed_i); // R9

    AST_RESET_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (rst_i)
        wd_rst_i |-> armed_i); // R10

endmodule

bind ostimer_wdog ostw_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ostw_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .cnt_i      (cnt_q),
    .match_i    (match_all),
    .status_i   (status_q),
    .irq_i      (irq_o),
    .armed_i    (armed_q),
    .wd_rst_i   (wd_rst_o)
);

// File: tb/ostimer_wdog_test.sv
module ostimer_wdog_test;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 32;
    localparam int AW         = 6;
    localparam int MARGIN     = 40;

    localparam logic [AW-1:0] A_M0   = 6'h00;
    localparam logic [AW-1:0] A_M3   = 6'h0C;
    localparam logic [AW-1:0] A_CNT  = 6'h10;
    localparam logic [AW-1:0] A_STAT = 6'h14;
    localparam logic [AW-1:0] A_WDEN = 6'h18;
    localparam logic [AW-1:0] A_IEN  = 6'h1C;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic          bus_re = 1'b0;
    logic [W-1:0]  bus_rdata;
    logic [3:0]    irq;
    logic          wd_rst;

    ostimer_wdog #(.CNT_W(W), .ADDR_W(AW)) uut (
        .clk_i       (clk),
        .rst_i       (rst),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_we_i    (bus_we),
        .bus_re_i    (bus_re),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq),
        .wd_rst_o    (wd_rst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int           n_cmp = 0;
    int           n_bad = 0;
    int           n_pulse = 0;
    logic [W-1:0] tb_cnt = '0;
    logic [W-1:0] pulse_at = '0;
    logic         done = 1'b0;

    // Reference counter from the requirements; pulse monitor samples pre-edge values.
    always @(posedge clk) begin
        if (rst)                              tb_cnt <= '0;
        else if (bus_we && bus_addr == A_CNT) tb_cnt <= bus_wdata;
        else                                  tb_cnt <= tb_cnt + 32'd1;
        if (!rst && wd_rst) begin
            n_pulse  <= n_pulse + 1;
            pulse_at <= tb_cnt;
        end
    end

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_now(input logic [AW-1:0] a, input logic [W-1:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_now(input logic [AW-1:0] a, output logic [W-1:0] d);
        bus_re = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_re = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [W-1:0] exp);
        logic [W-1:0] d;
        rd_now(a, d);
        check(req, d, exp);
    endtask

    task automatic wait_until(input logic [W-1:0] v);
        while (tb_cnt != v) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        logic [W-1:0] d;
        logic [W-1:0] m;
        logic [W-1:0] mval [4];
        int p0;

        do_reset();
        // R11: everything cleared
        for (int n = 0; n < 4; n++) rd_chk("R11 match after reset", 6'(n * 4), '0);
        rd_chk("R11 status after reset", A_STAT, '0);
        rd_chk("R11 arm after reset", A_WDEN, '0);
        rd_chk("R11 ien after reset", A_IEN, '0);
        rd_chk("R11 counter after reset", A_CNT, tb_cnt);
        check("R11 irq after reset", 32'(irq), '0);
        check("R11 wd_rst after reset", 32'(wd_rst), '0);

        // R1: counter tracks one per clock
        for (int i = 0; i < 5; i++) begin
            repeat (3) @(negedge clk);
            rd_chk("R1 counter step", A_CNT, tb_cnt);
        end

        // R12: read strobe low gives zero
        bus_addr = A_CNT; bus_re = 1'b0;
        #1 check("R12 rdata with re low", bus_rdata, '0);
        @(negedge clk);

        // R2: flag per channel rises exactly when counter lands on match
        for (int n = 0; n < 4; n++) begin
            m = tb_cnt + 32'(6 + n);
            mval[n] = m;
            wr_now(6'(n * 4), m);
            wait_until(m - 32'd1);
            rd_now(A_STAT, d);
            check("R2 flag before match", 32'(d[n]), 32'd0);
            @(negedge clk);
            rd_now(A_STAT, d);
            check("R2 flag at match", 32'(d[n]), 32'd1);
        end
        rd_chk("R2 all flags set", A_STAT, 32'hF);

        // R5: interrupt gating sweep over all enable patterns
        for (int e = 0; e < 16; e++) begin
            wr_now(A_IEN, 32'(e));
            check("R5 irq gate full status", 32'(irq), 32'(e));
        end

        // R3: write-one-to-clear, zero bits untouched
        wr_now(A_STAT, 32'h5);
        rd_chk("R3 clear bits 0 and 2", A_STAT, 32'hA);
        check("R5 irq gate partial status", 32'(irq), 32'hA);
        wr_now(A_STAT, 32'h0);
        rd_chk("R3 write zero keeps flags", A_STAT, 32'hA);
        wr_now(A_STAT, 32'h2);
        rd_chk("R3 clear bit 1", A_STAT, 32'h8);

        // R4: match on the same edge as a clear wins
        m = tb_cnt + 32'd8;
        mval[1] = m;
        wr_now(A_M0 + 6'h04, m);
        wait_until(m - 32'd1);
        wr_now(A_STAT, 32'h2);
        rd_now(A_STAT, d);
        check("R4 match beats clear", 32'(d[1]), 32'd1);

        // R12: holes ignore writes and read as zero
        wr_now(6'h20, 32'hFFFF_FFFF);
        wr_now(6'h02, 32'hFFFF_FFFF);
        wr_now(6'h11, 32'hFFFF_FFFF);
        wr_now(6'h3C, 32'hFFFF_FFFF);
        for (int n = 0; n < 4; n++) rd_chk("R12 match unchanged", 6'(n * 4), mval[n]);
        rd_chk("R12 ien unchanged", A_IEN, 32'hF);
        rd_chk("R12 arm unchanged", A_WDEN, '0);
        rd_chk("R12 counter unchanged", A_CNT, tb_cnt);
        rd_chk("R12 read hole 0x20", 6'h20, '0);
        rd_chk("R12 read unaligned", 6'h16, '0);

        // R6 and R1: wrap and compare across it
        wr_now(A_STAT, 32'hF);
        wr_now(A_M0, 32'd2);
        wr_now(A_CNT, 32'hFFFF_FFF0);
        rd_chk("R1 counter load", A_CNT, 32'hFFFF_FFF0);
        wait_until(32'd1);
        rd_now(A_STAT, d);
        check("R6 no flag before wrap match", 32'(d[0]), 32'd0);
        @(negedge clk);
        rd_now(A_STAT, d);
        check("R6 flag after wrap", 32'(d[0]), 32'd1);
        rd_chk("R1 counter wrapped", A_CNT, 32'd2);
        check("R6 irq after wrap", 32'(irq[0]), 32'd1);

        // R10: unarmed channel 3 match does not reset
        wr_now(A_STAT, 32'hF);
        wr_now(A_IEN, 32'h8);
        m = tb_cnt + 32'd10;
        wr_now(A_M3, m);
        p0 = n_pulse;
        wait_until(m + 32'd2);
        check("R10 no pulse unarmed", 32'(n_pulse - p0), 32'd0);
        rd_chk("R10 flag 3 set", A_STAT, 32'h8);
        check("R10 irq 3", 32'(irq), 32'h8);

        // R7: armed, no keepalive
        do_reset();
        rd_chk("R11 arm cleared by reset", A_WDEN, '0);
        m = tb_cnt + 32'(MARGIN);
        wr_now(A_M3, m);
        wr_now(A_WDEN, 32'd1);
        rd_chk("R7 armed reads 1", A_WDEN, 32'd1);
        p0 = n_pulse;
        wait_until(m - 32'd1);
        check("R7 no pulse before match", 32'(wd_rst), 32'd0);
        @(negedge clk);
        check("R7 pulse at match", 32'(wd_rst), 32'd1);
        @(negedge clk);
        check("R7 pulse one cycle", 32'(wd_rst), 32'd0);
        check("R7 single pulse", 32'(n_pulse - p0), 32'd1);
        check("R7 pulse position", pulse_at, m);

        // R8: keepalives in time hold off the reset
        do_reset();
        m = tb_cnt + 32'(MARGIN);
        wr_now(A_M3, m);
        wr_now(A_WDEN, 32'd1);
        p0 = n_pulse;
        for (int k = 0; k < 15; k++) begin
            repeat (30) @(negedge clk);
            m = tb_cnt + 32'(MARGIN);
            wr_now(A_M3, m);
        end
        check("R8 no pulse while kicked", 32'(n_pulse - p0), 32'd0);
        wait_until(m + 32'd1);
        check("R8 pulse after kicks stop", 32'(n_pulse - p0), 32'd1);
        check("R8 pulse position", pulse_at, m);

        // R9: disarm attempts are ineffective
        do_reset();
        wr_now(A_IEN, 32'h8);
        m = tb_cnt + 32'(MARGIN);
        wr_now(A_M3, m);
        wr_now(A_WDEN, 32'd1);
        wr_now(A_WDEN, 32'd0);
        wr_now(A_IEN, 32'd0);
        rd_chk("R9 arm still reads 1", A_WDEN, 32'd1);
        rd_chk("R9 ien cleared", A_IEN, 32'd0);
        p0 = n_pulse;
        wait_until(m + 32'd1);
        check("R9 pulse despite disarm", 32'(n_pulse - p0), 32'd1);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL timeout R1-watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule